// File: doc/BRIEF.md
# Serial Timing-Reference Word Framer

This block sits after the serial decoder of a 270 Mb/s video receiver. It takes one decoded bit on every serial clock and builds ten-bit parallel words, least-significant bit first. It runs a free divide-by-ten phase counter from reset. It watches every bit position for the three-word timing preamble (3FF, 000, 000). When that pattern completes, the counter is pulled back to its starting phase, so that the next ten bits form the identification word and all later words line up with the reference.

Each completed word is first captured in a readout register on the tenth bit. It is then handed to the output at the middle of the next word period, which is the opposite phase of the divided word clock. A one-cycle strobe marks each new output word. A horizontal flag follows the type of each identification word: bit 6 set means end of active video, and bit 6 clear means start of active video. The flag changes on the same strobe that presents the identification word. While the decode path upstream is bypassed, the flag carries no meaning and is held. Framing carries on unchanged in that mode.

Top module: `trs_framer`

## Requirements
- R1: An output word holds ten consecutive serial bits, with the earliest bit in word_out[0] and the latest in word_out[9].
- R2: word_stb is high for exactly one serial clock per output word. In steady framing there are ten clocks between strobes.
- R3: The preamble is ten 1 bits followed by twenty 0 bits in arrival order. It is recognised at any bit offset. The bit after its last bit becomes bit 0 of the identification word.
- R4: A word's strobe and new word_out value appear at the clock edge five edges after the edge that captured the word's last bit.
- R5: word_out and h_flag change only in a cycle where word_stb is high. They are stable in every other cycle.
- R6: An identification word with bit 6 = 1 sets h_flag to 1 on the strobe that presents it.
- R7: An identification word with bit 6 = 0 clears h_flag to 0 on the strobe that presents it.
- R8: Words that are not identification words never change h_flag, whatever their bit 6.
- R9: While bypass is high at the presenting edge, h_flag holds its value. Word framing and output are unaffected by bypass.
- R10: After an active-low reset, word_out is 0, word_stb is 0 and h_flag is 0. The first word is made of the first ten bits after reset.
- R11: A partly assembled word that is cut short by a preamble realignment is discarded and never strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Decoded serial bit, sampled on each rising edge |
| bypass | input | 1 | High while the upstream decode path is bypassed; freezes h_flag |
| word_out | output | 10 | Assembled parallel word |
| word_stb | output | 1 | One-clock pulse when word_out takes a new word |
| h_flag | output | 1 | Horizontal flag: 1 after end-of-active, 0 after start-of-active |

## Verification
A wrong phase counter shows up as strobes off the every-ten cadence, or as words that are a rotated slice of the sent data. Both are visible on the first strobe after the fault, at most ten clocks later. A preamble matcher that misses or fires falsely leaves the identification word misframed. That error appears at the ID word's strobe, fifteen clocks after the preamble ends, and h_flag then takes the wrong value or fails to move. A stuck pending or ID marker shows as a missing, repeated or wrongly timed strobe, or as h_flag moving on an ordinary data word within one word period.

// File: rtl/trs_framer.sv
module trs_framer #(
  parameter int W      = 10,
  parameter int ID_BIT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bypass,
  output logic [W-1:0] word_out,
  output logic         word_stb,
  output logic         h_flag
);

  localparam int SW = 3 * W;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] MID  = CW'(W / 2 - 1);
  localparam logic [SW-1:0] PRE  = {{(2 * W){1'b0}}, {W{1'b1}}};

  logic [SW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rd;
  logic          pend, rd_id, id_next;

  wire hit  = (sr == PRE);
  wire done = !hit && (cnt == LAST);
  wire xfer = pend && (cnt == MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      rd      <= '0;
      pend    <= 1'b0;
      rd_id   <= 1'b0;
      id_next <= 1'b0;
    end else begin
      sr <= {bit_in, sr[SW-1:1]};
      if (hit) begin
        cnt     <= CW'(1);
        id_next <= 1'b1;
      end else if (done) begin
        cnt     <= '0;
        rd      <= {bit_in, sr[SW-1:SW-W+1]};
        rd_id   <= id_next;
        id_next <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
      if (done)      pend <= 1'b1;
      else if (xfer) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      word_stb <= 1'b0;
      h_flag   <= 1'b0;
    end else begin
      word_stb <= xfer;
      if (xfer) begin
        word_out <= rd;
        if (rd_id && !bypass) h_flag <= rd[ID_BIT];
      end
    end
  end

endmodule

// File: rtl/trs_framer_chk.sv
module trs_framer_chk #(
  parameter int W      = 10,
  parameter int ID_BIT = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bypass,
  input logic [W-1:0] word_out,
  input logic         word_stb,
  input logic         h_flag
);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> $stable(word_out));

  a_r5_h_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> $stable(h_flag));

  a_r9_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> $stable(h_flag));

  a_r6_h_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !$stable(h_flag)) |-> (h_flag == word_out[ID_BIT]));

endmodule

bind trs_framer trs_framer_chk #(.W(W), .ID_BIT(ID_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass),
  .word_out(word_out), .word_stb(word_stb), .h_flag(h_flag)
);

// File: tb/trs_framer_test.sv
module trs_framer_test;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bypass = 1'b0;
  logic [W-1:0] word_out;
  logic word_stb;
  logic h_flag;

  always #5 clk = ~clk;

  trs_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bypass(bypass),
    .word_out(word_out), .word_stb(word_stb), .h_flag(h_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  string tag = "R10";

  logic [29:0] m_hist = '0;
  int          m_cnt = 0;
  logic        m_pend = 1'b0, m_rdid = 1'b0, m_idx = 1'b0;
  logic [9:0]  m_rd = '0, m_out = '0;
  logic        m_stb = 1'b0, m_h = 1'b0;

  localparam logic [29:0] PRE = {20'h0, 10'h3FF};

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [9:0] assemble(input logic [29:0] h, input logic b);
    return {b, h[29:21]};
  endfunction

  task automatic model(input logic b, input logic byp);
    logic match;
    match = (m_hist == PRE);
    m_stb = 1'b0;
    if (m_cnt == 4 && m_pend) begin
      m_out  = m_rd;
      m_stb  = 1'b1;
      m_pend = 1'b0;
      if (m_rdid && !byp) m_h = m_rd[6];
    end
    if (match) begin
      m_cnt = 1;
      m_idx = 1'b1;
    end else if (m_cnt == 9) begin
      m_rd   = assemble(m_hist, b);
      m_rdid = m_idx;
      m_idx  = 1'b0;
      m_pend = 1'b1;
      m_cnt  = 0;
    end else begin
      m_cnt++;
    end
    m_hist = {b, m_hist[29:1]};
  endtask

  task automatic step(input logic b, input logic byp);
    bit_in = b;
    bypass = byp;
    @(posedge clk);
    model(b, byp);
    @(negedge clk);
    check({tag, " R2 R4"}, "strobe", 32'(word_stb), 32'(m_stb));
    check({tag, " R1 R5"}, "word", 32'(word_out), 32'(m_out));
    check({tag, " R6 R7 R8"}, "hflag", 32'(h_flag), 32'(m_h));
  endtask

  task automatic send_word(input logic [9:0] w, input logic byp);
    for (int i = 0; i < 10; i++) step(w[i], byp);
  endtask

  task automatic send_pre(input logic byp);
    send_word(10'h3FF, byp);
    send_word(10'h000, byp);
    send_word(10'h000, byp);
  endtask

  function automatic logic [9:0] rnd_word();
    return 10'($urandom_range(32'h3FB, 32'h004));
  endfunction

  task automatic rnd_words(input int n, input logic byp);
    for (int i = 0; i < n; i++) send_word(rnd_word(), byp);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #500us;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R10", "reset word", 32'(word_out), 32'h0);
    check("R10", "reset strobe", 32'(word_stb), 32'h0);
    check("R10", "reset hflag", 32'(h_flag), 32'h0);
    rst_n = 1'b1;

    tag = "R10";
    send_word(10'h2A5, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    check("R10 R1", "first word after reset", 32'(word_out), 32'h2A5);

    tag = "R2";
    for (int i = 0; i < 150; i++) step(1'($urandom_range(1, 0)), 1'b0);

    tag = "R3 R11";
    for (int off = 0; off < 10; off++) begin
      for (int k = 0; k < off; k++) step(1'($urandom_range(1, 0)), 1'b0);
      send_pre(1'b0);
      send_word((off % 2 == 0) ? 10'h274 : 10'h200, 1'b0);
      rnd_words(3, 1'b0);
      check("R3", "ID framing at offset", 32'(h_flag), (off % 2 == 0) ? 32'h1 : 32'h0);
    end

    tag = "R6";
    send_pre(1'b0);
    send_word(10'h274, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    check("R6", "ID word on port", 32'(word_out), 32'h274);
    check("R6", "hflag after end-of-active", 32'(h_flag), 32'h1);

    tag = "R8";
    for (int i = 0; i < 4; i++) send_word(10'h0A5, 1'b0);
    check("R8", "hflag after data bit6=0", 32'(h_flag), 32'h1);

    tag = "R7";
    send_pre(1'b0);
    send_word(10'h200, 1'b0);
    send_word(10'h155, 1'b0);
    check("R7", "hflag after start-of-active", 32'(h_flag), 32'h0);
    for (int i = 0; i < 4; i++) send_word(10'h1C4, 1'b0);
    check("R8", "hflag after data bit6=1", 32'(h_flag), 32'h0);

    tag = "R9";
    send_pre(1'b1);
    send_word(10'h274, 1'b1);
    send_word(10'h133, 1'b1);
    check("R9", "hflag held in bypass", 32'(h_flag), 32'h0);
    check("R9", "framing in bypass", 32'(word_out), 32'h274);

    tag = "R11";
    send_word(10'h155, 1'b0);
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0);
    send_pre(1'b0);
    send_word(10'h274, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    check("R11", "realigned ID word", 32'(word_out), 32'h274);

    tag = "R1 R5";
    for (int r = 0; r < 40; r++) begin
      int gap;
      gap = int'($urandom_range(25, 0));
      for (int k = 0; k < gap; k++) step(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      if ($urandom_range(1, 0) == 1) begin
        send_pre(1'b0);
        send_word($urandom_range(1, 0) == 1 ? 10'h274 : 10'h200, 1'($urandom_range(1, 0)));
      end
      rnd_words(int'($urandom_range(4, 1)), 1'b0);
    end

    summary();
  end
endmodule